// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This block holds a set of independent interval timer channels behind a simple word-addressed register bus. Software programs a reload value, chooses a count direction, and arms a channel by writing its control word. The channel then counts one step per pulse of an external prescaler strobe. When it expires it sets a sticky interrupt flag. It then either stops or reloads itself and keeps running, as its control word selects.

All channels feed one shared interrupt line. Each channel contributes only when its interrupt-enable bit is set. Software clears a flag by writing the channel's control word, and that write re-arms or stops the channel at the same time. Several control bits are stored and read back but have no effect: capture, PWM, generate output, cascade, the load strobe and enable-all.

Top module: `mm_interval_timer`

## Requirements
- R1: Each channel occupies four words. The address bits above the low two select the channel. Offset 0 is control, offset 1 is reload value, offset 2 is the live count, and offset 3 reads as zero. Read data appears on `rdata` in the cycle after `rd_en`.
- R2: After reset every register reads zero, every channel is stopped and `irq` is low.
- R3: A control write with bit 7 (run) at 1 copies the reload value into the count and starts the channel. A control write with bit 7 at 0 stops it. A running channel moves only on cycles where `tick_en` is high, and a stopped channel's count never changes.
- R4: With control bit 1 at 1 the count decrements on each tick. A tick that finds the count at zero is an expiry.
- R5: With control bit 1 at 0 the count increments on each tick. A tick that finds the count at all-ones is an expiry.
- R6: An expiry sets the flag, which reads back as control bit 8. If control bit 4 (auto-reload) is set, the count is reloaded and the channel keeps running. Otherwise the channel stops and holds its count.
- R7: Any control write clears the flag, whatever value bit 8 carries. Only an expiry sets the flag. If an expiry and a control write reach the same channel in the same cycle, the flag ends up set.
- R8: `irq` is high one cycle after any channel has both its flag and its control bit 6 (interrupt enable) set, and low one cycle after none has.
- R9: A write to the reload value leaves a running count unchanged. The new value is used at the next start or auto-reload.
- R10: Control bits 0, 2, 3, 5, 9 and 10 are stored and read back with no effect on counting, and bits 31 to 11 read as zero. Writes to offsets 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe from the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address: channel index and offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The count path is driven in down mode from a small reload value and in up mode from just below all-ones. These two runs tell apart the zero and all-ones expiry points, and both show that the count holds still once a one-shot channel stops. An auto-reload run in which the reload value is rewritten mid-count separates the old reload from the new one. Further runs set flags with the interrupt enable on and off, which shows the enable gating of the shared line. A control write issued in the same cycle as an expiry shows which of the two sets the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_LOAD  = 1;
  localparam int OFS_COUNT = 2;

  localparam int B_DOWN   = 1;
  localparam int B_RELOAD = 4;
  localparam int B_IE     = 6;
  localparam int B_RUN    = 7;
  localparam int B_FLAG   = 8;

  localparam int CTRL_W = 11;
  // every control bit except the flag is kept as written
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 11'h6FF;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_en,
  input  logic                      ctrl_we,
  input  logic                      load_we,
  input  logic [31:0]               wdata,
  output logic [CTRL_W-1:0]         ctrl_q,
  output logic [CNT_W-1:0]          load_q,
  output logic [CNT_W-1:0]          count_q,
  output logic                      irq_req
);
  logic [CTRL_W-1:0] cfg;
  logic              run;
  logic              flag;
  logic              at_end;
  logic              expire;

  assign at_end = cfg[B_DOWN] ? (count_q == '0) : (count_q == '1);
  assign expire = run && tick_en && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      load_q  <= '0;
      count_q <= '0;
      run     <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (load_we) load_q <= wdata[CNT_W-1:0];
      if (ctrl_we) cfg <= wdata[CTRL_W-1:0] & CTRL_KEEP;

      if (expire)       flag <= 1'b1;
      else if (ctrl_we) flag <= 1'b0;

      if (ctrl_we) begin
        if (wdata[B_RUN]) begin
          count_q <= load_q;
          run     <= 1'b1;
        end else begin
          run     <= 1'b0;
        end
      end else if (run && tick_en) begin
        if (at_end) begin
          if (cfg[B_RELOAD]) count_q <= load_q;
          else               run     <= 1'b0;
        end else if (cfg[B_DOWN]) begin
          count_q <= count_q - 1'b1;
        end else begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl_q         = cfg;
    ctrl_q[B_FLAG] = flag;
  end
  assign irq_req = flag & cfg[B_IE];

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && wdata[B_RUN]) |=> (run && count_q == $past(load_q)));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !ctrl_we) |=> $stable(count_q));

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(expire));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !expire) |=> !flag);

  // R9
  load_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (load_we && !tick_en) |=> $stable(count_q));
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NUM_CH-1:0][31:0] ctrl_w,
  input  logic [NUM_CH-1:0][31:0] load_w,
  input  logic [NUM_CH-1:0][31:0] cnt_w,
  output logic [31:0]            rdata
);
  logic [31:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(addr[ADDR_W-1:2]) == i) begin
        case (addr[1:0])
          2'd0:    sel = ctrl_w[i];
          2'd1:    sel = load_w[i];
          2'd2:    sel = cnt_w[i];
          default: sel = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  // R1
  pad_word_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[1:0] == 2'd3) |=> (rdata == 32'd0));
endmodule

// File: rtl/tmr_irq_merge.sv
module tmr_irq_merge #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |req;
  end

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> !irq);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> irq);
endmodule

// File: rtl/mm_interval_timer.sv
module mm_interval_timer
  import tmr_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int CNT_W  = 32,
  localparam int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_AW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic [NUM_CH-1:0][31:0] ctrl_w;
  logic [NUM_CH-1:0][31:0] load_w;
  logic [NUM_CH-1:0][31:0] cnt_w;
  logic [NUM_CH-1:0]       req;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             hit;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  count_q;

    assign hit = wr_en && (int'(addr[ADDR_W-1:2]) == c);

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .tick_en (tick_en),
      .ctrl_we (hit && addr[1:0] == 2'(OFS_CTRL)),
      .load_we (hit && addr[1:0] == 2'(OFS_LOAD)),
      .wdata   (wdata),
      .ctrl_q  (ctrl_q),
      .load_q  (load_q),
      .count_q (count_q),
      .irq_req (req[c])
    );

    assign ctrl_w[c] = 32'(ctrl_q);
    assign load_w[c] = 32'(load_q);
    assign cnt_w[c]  = 32'(count_q);
  end

  tmr_read_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .ctrl_w (ctrl_w),
    .load_w (load_w),
    .cnt_w  (cnt_w),
    .rdata  (rdata)
  );

  tmr_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
    .clk (clk),
    .rst (rst),
    .req (req),
    .irq (irq)
  );

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq && rdata == 32'd0));
endmodule

// File: tb/mm_interval_timer_tb_top.sv
module mm_interval_timer_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mm_interval_timer #(.NUM_CH(4), .CNT_W(32)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int ch, input int ofs, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(ch*4 + ofs); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input int ch, input int ofs, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(ch*4 + ofs);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R2 irq", {31'd0, irq}, 32'd0);
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 3; o++) begin
        bus_read(c, o, v);
        check("R2 reg", v, 32'd0);
      end
    end
    tick(4);
    bus_read(1, 2, v);
    check("R2 stopped", v, 32'd0);
  endtask

  task automatic t_down;
    logic [31:0] v;
    bus_write(0, 1, 32'd5);
    bus_write(0, 0, 32'h0000_00C2);
    bus_read(0, 2, v); check("R3 start", v, 32'd5);
    tick(3);
    bus_read(0, 2, v); check("R4 down", v, 32'd2);
    tick(2);
    bus_read(0, 0, v); check("R4 no early expiry", v, 32'h0000_00C2);
    tick(1);
    bus_read(0, 0, v); check("R6 flag set", v, 32'h0000_01C2);
    check("R8 irq on", {31'd0, irq}, 32'd1);
    tick(2);
    bus_read(0, 2, v); check("R6 one-shot holds", v, 32'd0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    bus_write(0, 0, 32'h0000_0142);
    bus_read(0, 0, v); check("R7 flag cleared", v, 32'h0000_0042);
    check("R8 irq off", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_up;
    logic [31:0] v;
    bus_write(1, 1, 32'hFFFF_FFFD);
    bus_write(1, 0, 32'h0000_0080);
    tick(2);
    bus_read(1, 2, v); check("R5 up", v, 32'hFFFF_FFFF);
    tick(1);
    bus_read(1, 0, v); check("R5 expiry", v, 32'h0000_0180);
    check("R8 masked", {31'd0, irq}, 32'd0);
    tick(2);
    bus_read(1, 2, v); check("R6 up stop", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    bus_write(2, 1, 32'd2);
    bus_write(2, 0, 32'h0000_00D2);
    tick(3);
    bus_read(2, 2, v); check("R6 reloaded", v, 32'd2);
    bus_read(2, 0, v); check("R6 reload flag", v, 32'h0000_01D2);
    tick(1);
    bus_read(2, 2, v); check("R6 keeps running", v, 32'd1);
    bus_write(2, 1, 32'd9);
    bus_read(2, 2, v); check("R9 count untouched", v, 32'd1);
    tick(2);
    bus_read(2, 2, v); check("R9 new reload", v, 32'd9);
    check("R8 irq reload", {31'd0, irq}, 32'd1);
    bus_write(2, 0, 32'h0000_0002);
    bus_read(2, 0, v); check("R7 clear ch2", v, 32'h0000_0002);
    check("R8 irq drops", {31'd0, irq}, 32'd0);
    tick(3);
    bus_read(2, 2, v); check("R3 stop holds", v, 32'd9);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    bus_write(3, 0, 32'hFFFF_F62D);
    bus_read(3, 0, v); check("R10 stored bits", v, 32'h0000_062D);
    tick(3);
    bus_read(3, 2, v); check("R10 no effect", v, 32'd0);
    bus_write(2, 2, 32'h0000_1234);
    bus_read(2, 2, v); check("R10 count write ignored", v, 32'd9);
    bus_write(2, 3, 32'hABCD_0000);
    bus_read(2, 3, v); check("R1 pad word", v, 32'd0);
    bus_read(2, 1, v); check("R1 load readback", v, 32'd9);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    bus_write(0, 1, 32'd0);
    bus_write(0, 0, 32'h0000_0082);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 4'd0; wdata = 32'h0000_0082;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    bus_read(0, 0, v); check("R7 expiry wins", v, 32'h0000_0182);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_down();
    t_clear();
    t_up();
    t_reload();
    t_misc();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule